// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This unit watches every bus-level access a core makes and compares its linear address against four programmable breakpoint slots. Each slot holds an address, a two-bit condition that picks which access kinds it reacts to, and two enables, one local and one global. A slot that matches always leaves a sticky status bit. A matching slot with either enable set also asks the core for a debug exception through a one-cycle fault pulse. Matching uses only the linear address, so it works the same whether or not paging is on.

A resume flag from the core is taken at each instruction boundary. While it is set, faults raised by the current instruction are dropped. A pair of exact-report enables picks when data breakpoints are reported. With either one set, a data hit is reported on the access itself. With both clear, the report waits until the next instruction boundary. A task-switch pulse clears the local exact enable and keeps the global one.

The control FSM has three states. OPEN means the current instruction may fault. MUTED means the resume flag was set at its start. DEFER means a data hit is waiting for the next boundary. At a boundary every state moves to MUTED if the sampled resume flag is 1, to DEFER if a deferred data hit arrives in that same cycle, and to OPEN otherwise. Between boundaries, OPEN moves to DEFER on a deferred data hit, and MUTED and DEFER hold. Leaving DEFER through a boundary emits the held fault.

Top module: `bp_match_unit`

## Requirements
- R1: After reset every configuration register reads 0, `bp_status` is 0 and `dbg_fault` is 0.
- R2: The configuration registers read back combinationally on `cfg_rdata`. Address 0 to 3 are the slot addresses. Address 4 is control: bits [3:0] are the local slot enables, [7:4] the global slot enables, bit 8 is the local exact enable, bit 9 the global exact enable, and bits [17+2i:16+2i] the condition of slot i. Address 5 is status, where writing 1 to a bit clears it.
- R3: The access kind encoding is 00 fetch, 01 read, 10 write and 11 none. A slot with condition 00 matches only a fetch at exactly its address.
- R4: A slot with condition 01 matches only a write at its address.
- R5: A slot with condition 10 never matches.
- R6: A slot with condition 11 matches a read or a write at its address, never a fetch.
- R7: Every matching slot sets its status bit in the cycle after the access, whatever its enables and the resume flag. The bit stays set until software writes 1 to it.
- R8: A match requests a fault only if the matching slot has its local or its global enable set.
- R9: The value of `rf_in` sampled with `insn_start` suppresses all faults until the next `insn_start`. Changes of `rf_in` between boundaries have no effect.
- R10: Execute hits, and data hits while an exact enable is set, pulse `dbg_fault` in the cycle after the access. A data hit with both exact enables clear pulses `dbg_fault` in the cycle after the next `insn_start`, even if that boundary sets the resume flag.
- R11: A `task_switch` pulse clears the local exact enable and leaves the global exact enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_lin_addr | input | 32 | Linear address of the access |
| acc_kind | input | 2 | Access kind: 00 fetch, 01 read, 10 write, 11 none |
| insn_start | input | 1 | Instruction boundary strobe |
| rf_in | input | 1 | Resume flag value, sampled with insn_start |
| task_switch | input | 1 | Task switch pulse |
| dbg_fault | output | 1 | Debug fault request pulse |
| bp_status | output | 4 | Sticky per-slot match status |

## Verification
Each slot gets fetch, read and write accesses at its own address. This separates the four condition codes and shows that the reserved code stays silent. An access one word off the breakpoint shows that matching is exact. The same hit is repeated with local only, global only and no enables, which separates status recording from fault requests. Hits placed before and after a resume-flag boundary, and a mid-instruction change of the flag, show that only the boundary sample counts. Data hits are reported with each exact enable alone and with neither. This is done before and after a task switch, which tells immediate, deferred and task-switch behaviour apart.

// File: rtl/bp_match_pkg.sv
package bp_match_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_NONE  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        COND_EXEC = 2'b00,
        COND_WR   = 2'b01,
        COND_RSVD = 2'b10,
        COND_RW   = 2'b11
    } bp_cond_e;

    typedef enum logic [1:0] {
        ST_OPEN  = 2'b00,
        ST_MUTED = 2'b01,
        ST_DEFER = 2'b10
    } bp_state_e;

    localparam int COND_BASE = 16;

endpackage

// File: rtl/bp_slot_cmp.sv
module bp_slot_cmp
    import bp_match_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] bp_addr,
    input  logic [1:0]        cond,
    output logic              hit,
    output logic              is_exec
);

    logic addr_eq;
    logic kind_ok;

    always_comb begin
        addr_eq = (acc_addr == bp_addr);
        kind_ok = 1'b0;
        unique case (bp_cond_e'(cond))
            COND_EXEC: kind_ok = (acc_kind == ACC_FETCH);
            COND_WR:   kind_ok = (acc_kind == ACC_WRITE);
            COND_RW:   kind_ok = (acc_kind == ACC_READ) || (acc_kind == ACC_WRITE);
            default:   kind_ok = 1'b0;
        endcase
        hit     = acc_valid && addr_eq && kind_ok;
        is_exec = (cond == COND_EXEC);
    end

    always_comb begin
        if (cond == COND_RSVD) begin
            assert_rsvd_never_hits_R5: assert (!hit);
        end
        if (cond == COND_RW && acc_kind == ACC_FETCH) begin
            assert_rw_ignores_fetch_R6: assert (!hit);
        end
    end

endmodule

// File: rtl/bp_regs.sv
module bp_regs
    import bp_match_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int RA_W      = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [RA_W-1:0]                   addr,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [DATA_W-1:0]                 rdata,
    input  logic                              task_sw,
    input  logic [NUM_SLOTS-1:0]              hit,
    output logic [NUM_SLOTS-1:0][ADDR_W-1:0]  bp_addr,
    output logic [NUM_SLOTS-1:0][1:0]         cond,
    output logic [NUM_SLOTS-1:0]              en_any,
    output logic                              exact,
    output logic [NUM_SLOTS-1:0]              status
);

    localparam int          LE_BIT   = 2 * NUM_SLOTS;
    localparam int          GE_BIT   = 2 * NUM_SLOTS + 1;
    localparam logic [RA_W-1:0] REG_CTRL = RA_W'(NUM_SLOTS);
    localparam logic [RA_W-1:0] REG_STAT = RA_W'(NUM_SLOTS + 1);

    logic [NUM_SLOTS-1:0] l_en;
    logic [NUM_SLOTS-1:0] g_en;
    logic                 le_q;
    logic                 ge_q;
    logic                 wr_ctrl;
    logic                 wr_stat;

    assign wr_ctrl = wr_en && (addr == REG_CTRL);
    assign wr_stat = wr_en && (addr == REG_STAT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_addr <= '0;
            cond    <= '0;
            l_en    <= '0;
            g_en    <= '0;
            le_q    <= 1'b0;
            ge_q    <= 1'b0;
            status  <= '0;
        end else begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (wr_en && addr == RA_W'(i)) begin
                    bp_addr[i] <= wdata[ADDR_W-1:0];
                end
                if (wr_ctrl) begin
                    cond[i] <= wdata[COND_BASE + 2*i +: 2];
                end
            end
            if (wr_ctrl) begin
                l_en <= wdata[NUM_SLOTS-1:0];
                g_en <= wdata[2*NUM_SLOTS-1:NUM_SLOTS];
                ge_q <= wdata[GE_BIT];
            end
            if (task_sw) begin
                le_q <= 1'b0;
            end else if (wr_ctrl) begin
                le_q <= wdata[LE_BIT];
            end
            status <= (status & ~(wr_stat ? wdata[NUM_SLOTS-1:0] : '0)) | hit;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr < RA_W'(NUM_SLOTS)) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (addr == RA_W'(i)) rdata[ADDR_W-1:0] = bp_addr[i];
            end
        end else if (addr == REG_CTRL) begin
            rdata[NUM_SLOTS-1:0]           = l_en;
            rdata[2*NUM_SLOTS-1:NUM_SLOTS] = g_en;
            rdata[LE_BIT]                  = le_q;
            rdata[GE_BIT]                  = ge_q;
            for (int i = 0; i < NUM_SLOTS; i++) begin
                rdata[COND_BASE + 2*i +: 2] = cond[i];
            end
        end else if (addr == REG_STAT) begin
            rdata[NUM_SLOTS-1:0] = status;
        end
    end

    assign en_any = l_en | g_en;
    assign exact  = le_q | ge_q;

    assert_ts_clears_le_R11: assert property (@(posedge clk) disable iff (!rst_n)
        task_sw |=> !le_q);

    assert_ts_keeps_ge_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (task_sw && !wr_ctrl) |=> $stable(ge_q));

    assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> ((status & $past(status)) == $past(status)));

endmodule

// File: rtl/bp_fsm.sv
module bp_fsm
    import bp_match_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic insn_start,
    input  logic rf_in,
    input  logic exec_armed,
    input  logic data_armed,
    input  logic exact,
    output logic fault
);

    bp_state_e state;
    bp_state_e state_nxt;
    logic      mute_now;
    logic      fire_now;
    logic      defer_new;
    logic      release_now;
    logic      fault_q;

    always_comb begin
        mute_now    = insn_start ? rf_in : (state == ST_MUTED);
        fire_now    = !mute_now && (exec_armed || (data_armed && exact));
        defer_new   = !mute_now && data_armed && !exact;
        release_now = (state == ST_DEFER) && insn_start;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OPEN: begin
                if (insn_start)     state_nxt = rf_in ? ST_MUTED : (defer_new ? ST_DEFER : ST_OPEN);
                else if (defer_new) state_nxt = ST_DEFER;
            end
            ST_MUTED: begin
                if (insn_start)     state_nxt = rf_in ? ST_MUTED : (defer_new ? ST_DEFER : ST_OPEN);
            end
            ST_DEFER: begin
                if (insn_start)     state_nxt = rf_in ? ST_MUTED : (defer_new ? ST_DEFER : ST_OPEN);
            end
            default:                state_nxt = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OPEN;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= fire_now || release_now;
    end

    assign fault = fault_q;

    assert_muted_no_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MUTED && !insn_start) |=> !fault);

    assert_defer_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEFER && insn_start) |=> fault);

    assert_no_arm_no_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_armed && !data_armed && state != ST_DEFER) |=> !fault);

endmodule

// File: rtl/bp_match_unit.sv
module bp_match_unit
    import bp_match_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    localparam int RA_W     = $clog2(NUM_SLOTS + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [RA_W-1:0]      cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    input  logic                 acc_valid,
    input  logic [ADDR_W-1:0]    acc_lin_addr,
    input  logic [1:0]           acc_kind,
    input  logic                 insn_start,
    input  logic                 rf_in,
    input  logic                 task_switch,
    output logic                 dbg_fault,
    output logic [NUM_SLOTS-1:0] bp_status
);

    logic [NUM_SLOTS-1:0][ADDR_W-1:0] bp_addr;
    logic [NUM_SLOTS-1:0][1:0]        cond;
    logic [NUM_SLOTS-1:0]             en_any;
    logic [NUM_SLOTS-1:0]             hit;
    logic [NUM_SLOTS-1:0]             is_exec;
    logic                             exact;
    logic                             exec_armed;
    logic                             data_armed;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        bp_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .acc_valid (acc_valid),
            .acc_addr  (acc_lin_addr),
            .acc_kind  (acc_kind),
            .bp_addr   (bp_addr[g]),
            .cond      (cond[g]),
            .hit       (hit[g]),
            .is_exec   (is_exec[g])
        );
    end

    bp_regs #(
        .NUM_SLOTS (NUM_SLOTS),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .RA_W      (RA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .task_sw (task_switch),
        .hit     (hit),
        .bp_addr (bp_addr),
        .cond    (cond),
        .en_any  (en_any),
        .exact   (exact),
        .status  (bp_status)
    );

    assign exec_armed = |(hit & en_any & is_exec);
    assign data_armed = |(hit & en_any & ~is_exec);

    bp_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_start (insn_start),
        .rf_in      (rf_in),
        .exec_armed (exec_armed),
        .data_armed (data_armed),
        .exact      (exact),
        .fault      (dbg_fault)
    );

    assert_hit_sets_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((bp_status & $past(hit)) == $past(hit)));

endmodule

// File: tb/bp_match_unit_tb.sv
module bp_match_unit_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_lin_addr = '0;
    logic [1:0]  acc_kind = 2'b11;
    logic        insn_start = 1'b0;
    logic        rf_in = 1'b0;
    logic        task_switch = 1'b0;
    logic        dbg_fault;
    logic [3:0]  bp_status;

    always #(CLK_PERIOD/2) clk = ~clk;

    bp_match_unit u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .acc_valid    (acc_valid),
        .acc_lin_addr (acc_lin_addr),
        .acc_kind     (acc_kind),
        .insn_start   (insn_start),
        .rf_in        (rf_in),
        .task_switch  (task_switch),
        .dbg_fault    (dbg_fault),
        .bp_status    (bp_status)
    );

    typedef struct {
        logic       f;
        logic [3:0] s;
        string      tag;
    } exp_t;

    exp_t       exp_q[$];
    int         n_run = 0;
    int         n_fail = 0;
    logic [3:0] cur_st = '0;
    bit         done = 1'b0;

    localparam logic [1:0] K_F = 2'b00, K_R = 2'b01, K_W = 2'b10;

    // Scoreboard monitor: results of the cycle pushed at a negedge appear after the next posedge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_run++;
            if (dbg_fault !== e.f || bp_status !== e.s) begin
                n_fail++;
                $display("FAIL %s: fault=%0b status=%b expected fault=%0b status=%b",
                         e.tag, dbg_fault, bp_status, e.f, e.s);
            end
        end
    end

    task automatic cyc(input logic v, input logic [31:0] a, input logic [1:0] k,
                       input logic ins, input logic rf, input logic ts,
                       input logic w, input logic [2:0] ra, input logic [31:0] wd,
                       input logic ef, input string tag);
        exp_t e;
        @(negedge clk);
        acc_valid = v; acc_lin_addr = a; acc_kind = k;
        insn_start = ins; rf_in = rf; task_switch = ts;
        cfg_wr = w; cfg_addr = ra; cfg_wdata = wd;
        e.f = ef; e.s = cur_st; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic acc(input logic [31:0] a, input logic [1:0] k, input logic ef,
                       input logic [3:0] st, input string tag);
        cur_st = st;
        cyc(1'b1, a, k, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'd0, ef, tag);
    endtask

    task automatic wr(input logic [2:0] ra, input logic [31:0] wd, input string tag);
        if (ra == 3'd5) cur_st = cur_st & ~wd[3:0];
        cyc(1'b0, 32'd0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, ra, wd, 1'b0, tag);
    endtask

    task automatic bnd(input logic rf, input logic ef, input string tag);
        cyc(1'b0, 32'd0, 2'b11, 1'b1, rf, 1'b0, 1'b0, 3'd0, 32'd0, ef, tag);
    endtask

    task automatic idle(input logic ef, input string tag);
        cyc(1'b0, 32'd0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 32'd0, ef, tag);
    endtask

    task automatic tsw(input string tag);
        cyc(1'b0, 32'd0, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 32'd0, 1'b0, tag);
    endtask

    task automatic rd(input logic [2:0] ra, input logic [31:0] expv, input string tag);
        cyc(1'b0, 32'd0, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, ra, 32'd0, 1'b0, tag);
        #1;
        n_run++;
        if (cfg_rdata !== expv) begin
            n_fail++;
            $display("FAIL %s: rdata=%h expected %h", tag, cfg_rdata, expv);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 6; i++) rd(3'(i), 32'd0, "R1 reset register read");
        idle(1'b0, "R1 reset outputs");

        // R2: programming and readback
        wr(3'd0, 32'h0000_1000, "R2 wr slot0");
        wr(3'd1, 32'h0000_2000, "R2 wr slot1");
        wr(3'd2, 32'h0000_3000, "R2 wr slot2");
        wr(3'd3, 32'h0000_4000, "R2 wr slot3");
        wr(3'd4, 32'h00E4_010F, "R2 wr control");
        rd(3'd1, 32'h0000_2000, "R2 read slot1");
        rd(3'd4, 32'h00E4_010F, "R2 read control");

        // R3: execute condition
        acc(32'h0000_1000, K_F, 1'b1, 4'b0001, "R3 fetch hit");
        wr(3'd5, 32'h1, "R7 clear status");
        acc(32'h0000_1000, K_R, 1'b0, 4'b0000, "R3 read ignored");
        acc(32'h0000_1004, K_F, 1'b0, 4'b0000, "R3 neighbour address ignored");

        // R4: write condition
        acc(32'h0000_2000, K_W, 1'b1, 4'b0010, "R4 write hit");
        wr(3'd5, 32'h2, "R7 clear status");
        acc(32'h0000_2000, K_R, 1'b0, 4'b0000, "R4 read ignored");
        acc(32'h0000_2000, K_F, 1'b0, 4'b0000, "R4 fetch ignored");

        // R5: reserved condition
        acc(32'h0000_3000, K_R, 1'b0, 4'b0000, "R5 read no match");
        acc(32'h0000_3000, K_W, 1'b0, 4'b0000, "R5 write no match");
        acc(32'h0000_3000, K_F, 1'b0, 4'b0000, "R5 fetch no match");

        // R6: read/write condition
        acc(32'h0000_4000, K_R, 1'b1, 4'b1000, "R6 read hit");
        idle(1'b0, "R7 status held");
        wr(3'd5, 32'h8, "R7 clear status");
        acc(32'h0000_4000, K_W, 1'b1, 4'b1000, "R6 write hit");
        wr(3'd5, 32'h8, "R7 clear status");
        acc(32'h0000_4000, K_F, 1'b0, 4'b0000, "R6 fetch ignored");

        // R8: enables
        wr(3'd4, 32'h00E4_010E, "R8 local0 off");
        acc(32'h0000_1000, K_F, 1'b0, 4'b0001, "R8 disabled slot records only");
        rd(3'd5, 32'h0000_0001, "R7 status readback");
        wr(3'd5, 32'h1, "R7 clear status");
        wr(3'd4, 32'h00E4_011E, "R8 global0 on");
        acc(32'h0000_1000, K_F, 1'b1, 4'b0001, "R8 global enable faults");
        wr(3'd5, 32'h1, "R7 clear status");

        // R9: resume flag
        bnd(1'b1, 1'b0, "R9 boundary rf=1");
        acc(32'h0000_1000, K_F, 1'b0, 4'b0001, "R9 exec hit muted");
        acc(32'h0000_2000, K_W, 1'b0, 4'b0011, "R9 mid-insn rf drop ignored");
        wr(3'd5, 32'h3, "R7 clear status");
        bnd(1'b0, 1'b0, "R9 boundary rf=0");
        acc(32'h0000_1000, K_F, 1'b1, 4'b0001, "R9 faults again");
        wr(3'd5, 32'h1, "R7 clear status");

        // R10: deferred data reporting
        wr(3'd4, 32'h00E4_001F, "R10 exact off");
        bnd(1'b0, 1'b0, "R10 boundary");
        acc(32'h0000_2000, K_W, 1'b0, 4'b0010, "R10 data hit deferred");
        idle(1'b0, "R10 still deferred");
        bnd(1'b1, 1'b1, "R10 release at boundary");
        wr(3'd5, 32'h2, "R7 clear status");
        acc(32'h0000_1000, K_F, 1'b0, 4'b0001, "R9 muted after release");
        wr(3'd5, 32'h1, "R7 clear status");
        bnd(1'b0, 1'b0, "R10 boundary");
        acc(32'h0000_1000, K_F, 1'b1, 4'b0001, "R10 exec immediate without exact");
        wr(3'd5, 32'h1, "R7 clear status");

        // R11: task switch on exact enables
        wr(3'd4, 32'h00E4_031F, "R11 both exact");
        tsw("R11 task switch");
        rd(3'd4, 32'h00E4_021F, "R11 local exact cleared, global kept");
        acc(32'h0000_2000, K_W, 1'b1, 4'b0010, "R10 global exact immediate");
        wr(3'd5, 32'h2, "R7 clear status");
        wr(3'd4, 32'h00E4_011F, "R11 local exact only");
        tsw("R11 task switch");
        rd(3'd4, 32'h00E4_001F, "R11 local exact cleared");
        acc(32'h0000_4000, K_R, 1'b0, 4'b1000, "R11 data hit now deferred");
        bnd(1'b0, 1'b1, "R10 deferred release");
        idle(1'b0, "R10 single pulse");

        @(negedge clk);
        acc_valid = 1'b0; cfg_wr = 1'b0; insn_start = 1'b0; task_switch = 1'b0;
        wait (exp_q.size() == 0);
        repeat (2) @(posedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: timeout actual=running expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule